// File: doc/BRIEF.md
# Branch Execution Trace Recorder

This block records the control-flow history of a processor core. It watches the retirement stream and keeps an entry only when an instruction leaves the straight-line path: a taken branch, a jump, a call, a return or an interrupt entry. Each entry pairs the program counter of the instruction that broke the flow with the program counter it went to. Plain sequential retirements are never stored.

The storage is a rolling window of the 16 most recent discontinuities. Once the window is full, a further discontinuity displaces the oldest entry and raises a sticky overflow flag. A level interrupt request tells software that the window is full. Software can then drain the entries through an indexed read port and clear the recorder, so a trace longer than the window can be built up. Index 0 always returns the newest entry. A recording enable input lets software pause capture without losing what is already held.

Top module: `flow_trace_top`

## Requirements
- R1: After reset, fillCount is 0, overflow is 0, fullIrq is 0, and every read index returns zero on both rdSrcPc and rdDstPc.
- R2: A cycle with retireValid=1, isJump=1, recEnable=1 and clearReq=0 stores the pair {srcPc, dstPc} as the newest entry. If fillCount was below 16, it then rises by exactly 1 at the next clock edge.
- R3: A cycle with retireValid=0, or with isJump=0 (a sequential retirement), changes neither the stored entries, fillCount nor overflow.
- R4: While recEnable=0, discontinuities are not stored, and fillCount, overflow and the stored entries stay unchanged.
- R5: The read port is combinational. rdIdx=0 returns the newest stored entry, and rdIdx=k returns the entry recorded k discontinuities before it. rdSrcPc carries the source PC and rdDstPc carries the target PC.
- R6: For any rdIdx greater than or equal to fillCount, both rdSrcPc and rdDstPc read as zero.
- R7: fullIrq is a level output that is 1 exactly while fillCount equals 16. It stays high until a clear.
- R8: A discontinuity recorded while fillCount is 16 becomes the newest entry and displaces the oldest one. All other entries move one index older, and fillCount stays 16.
- R9: overflow is set by the first discontinuity recorded while the window is full. It remains 1 until a clear.
- R10: clearReq=1 makes fillCount 0, overflow 0 and fullIrq 0 at the next clock edge. A discontinuity presented in the same cycle as clearReq is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retireValid | input | 1 | An instruction retires this cycle |
| isJump | input | 1 | The retiring instruction left the sequential path |
| srcPc | input | 32 | PC of the retiring instruction |
| dstPc | input | 32 | PC that execution continues at |
| recEnable | input | 1 | Recording enable |
| clearReq | input | 1 | One-cycle clear command |
| rdIdx | input | 4 | Read index, 0 = newest |
| rdSrcPc | output | 32 | Source PC of the selected entry |
| rdDstPc | output | 32 | Target PC of the selected entry |
| fillCount | output | 5 | Number of valid entries, 0 to 16 |
| overflow | output | 1 | Sticky flag: an entry was displaced |
| fullIrq | output | 1 | Level interrupt request while full |

## Verification
The bench wraps the window well past 16 entries. A design with an off-by-one read pointer would then return the wrong pair at index 0 or at index 15, and a design that stopped writing once full would leave stale entries behind. The bench reads indices at and beyond fillCount after partial fills and after a clear. This catches a read port that exposes old contents. It also presents a discontinuity in the same cycle as a clear, which would leave fillCount at 1 if recording took priority. Long stretches of sequential retirements and of disabled recording would show a missing qualifier as a count that creeps up.

// File: rtl/flow_trace_pkg.sv
package flow_trace_pkg;
  // Strobes the control sends to the datapath for one clock
  typedef struct packed {
    logic doRec;     // store {src,dst} as newest entry
    logic doClr;     // reset the write pointer
    logic overwrite; // this store displaces the oldest entry
  } trcStrobe_t;
endpackage

// File: rtl/flow_trace_ctrl.sv
module flow_trace_ctrl
  import flow_trace_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retireValid,
  input  logic             isJump,
  input  logic             recEnable,
  input  logic             clearReq,
  output trcStrobe_t       strobe,
  output logic [CNT_W-1:0] fillCount,
  output logic             overflow,
  output logic             fullIrq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             takeBranch;
  logic             isFull;
  logic [CNT_W-1:0] cntNext;
  logic             ovfNext;

  assign isFull     = (fillCount == FULL_CNT);
  assign takeBranch = retireValid & isJump & recEnable;

  always_comb begin
    strobe.doClr     = clearReq;
    strobe.doRec     = takeBranch & ~clearReq;
    strobe.overwrite = takeBranch & ~clearReq & isFull;
  end

  always_comb begin
    cntNext = fillCount;
    ovfNext = overflow;
    if (strobe.doClr) begin
      cntNext = '0;
      ovfNext = 1'b0;
    end else if (strobe.doRec) begin
      if (strobe.overwrite) ovfNext = 1'b1;
      else                  cntNext = fillCount + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
      overflow  <= 1'b0;
      fullIrq   <= 1'b0;
    end else begin
      fillCount <= cntNext;
      overflow  <= ovfNext;
      fullIrq   <= (cntNext == FULL_CNT);
    end
  end
endmodule

// File: rtl/flow_trace_dp.sv
module flow_trace_dp
  import flow_trace_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  trcStrobe_t       strobe,
  input  logic [PC_W-1:0]  srcPc,
  input  logic [PC_W-1:0]  dstPc,
  input  logic [CNT_W-1:0] fillCount,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [PC_W-1:0]  rdSrcPc,
  output logic [PC_W-1:0]  rdDstPc
);
  // Ring storage: wrPtr points at the slot the next entry goes to,
  // so the newest entry sits one slot behind it.
  logic [PC_W-1:0]  srcMem [DEPTH];
  logic [PC_W-1:0]  dstMem [DEPTH];
  logic [IDX_W-1:0] wrPtr;
  logic [IDX_W-1:0] rdSlot;
  logic             rdValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             wrPtr <= '0;
    else if (strobe.doClr) wrPtr <= '0;
    else if (strobe.doRec) wrPtr <= wrPtr + IDX_W'(1);
  end

  always_ff @(posedge clk) begin
    if (strobe.doRec) begin
      srcMem[wrPtr] <= srcPc;
      dstMem[wrPtr] <= dstPc;
    end
  end

  assign rdSlot  = wrPtr - IDX_W'(1) - rdIdx;
  assign rdValid = (CNT_W'(rdIdx) < fillCount);

  always_comb begin
    rdSrcPc = '0;
    rdDstPc = '0;
    if (rdValid) begin
      rdSrcPc = srcMem[rdSlot];
      rdDstPc = dstMem[rdSlot];
    end
  end
endmodule

// File: rtl/flow_trace_top.sv
module flow_trace_top
  import flow_trace_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retireValid,
  input  logic             isJump,
  input  logic [PC_W-1:0]  srcPc,
  input  logic [PC_W-1:0]  dstPc,
  input  logic             recEnable,
  input  logic             clearReq,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [PC_W-1:0]  rdSrcPc,
  output logic [PC_W-1:0]  rdDstPc,
  output logic [CNT_W-1:0] fillCount,
  output logic             overflow,
  output logic             fullIrq
);
  trcStrobe_t strobe;

  flow_trace_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .retireValid(retireValid), .isJump(isJump),
    .recEnable(recEnable), .clearReq(clearReq),
    .strobe(strobe), .fillCount(fillCount),
    .overflow(overflow), .fullIrq(fullIrq)
  );

  flow_trace_dp #(.DEPTH(DEPTH), .PC_W(PC_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcPc(srcPc), .dstPc(dstPc), .fillCount(fillCount),
    .rdIdx(rdIdx), .rdSrcPc(rdSrcPc), .rdDstPc(rdDstPc)
  );
endmodule

// File: rtl/flow_trace_chk.sv
module flow_trace_chk #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             retireValid,
  input logic             isJump,
  input logic             recEnable,
  input logic             clearReq,
  input logic [IDX_W-1:0] rdIdx,
  input logic [PC_W-1:0]  rdSrcPc,
  input logic [PC_W-1:0]  rdDstPc,
  input logic [CNT_W-1:0] fillCount,
  input logic             overflow,
  input logic             fullIrq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  logic rec;
  assign rec = retireValid & isJump & recEnable & ~clearReq;

  a_r2_count_inc: assert property (@(posedge clk) disable iff (!rstN)
    (rec && fillCount != FULL_CNT) |=> fillCount == CNT_W'($past(fillCount) + CNT_W'(1)));

  a_r3_seq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!(retireValid && isJump) && !clearReq) |=> ($stable(fillCount) && $stable(overflow)));

  a_r4_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!recEnable && !clearReq) |=> ($stable(fillCount) && $stable(overflow)));

  a_r6_empty_read: assert property (@(posedge clk) disable iff (!rstN)
    (CNT_W'(rdIdx) >= fillCount) |-> (rdSrcPc == '0 && rdDstPc == '0));

  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    fullIrq == (fillCount == FULL_CNT));

  a_r8_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rec && fillCount == FULL_CNT) |=> (fillCount == FULL_CNT && overflow));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (overflow && !clearReq) |=> overflow);

  a_r10_clear: assert property (@(posedge clk) disable iff (!rstN)
    clearReq |=> (fillCount == '0 && !overflow && !fullIrq));
endmodule

bind flow_trace_top flow_trace_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) chk_i (
  .clk(clk), .rstN(rstN), .retireValid(retireValid), .isJump(isJump),
  .recEnable(recEnable), .clearReq(clearReq), .rdIdx(rdIdx),
  .rdSrcPc(rdSrcPc), .rdDstPc(rdDstPc), .fillCount(fillCount),
  .overflow(overflow), .fullIrq(fullIrq)
);

// File: tb/flow_trace_top_tb_top.sv
`timescale 1ns/100ps
module flow_trace_top_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        retireValid, isJump, recEnable, clearReq;
  logic [31:0] srcPc, dstPc;
  logic [3:0]  rdIdx;
  logic [31:0] rdSrcPc, rdDstPc;
  logic [4:0]  fillCount;
  logic        overflow, fullIrq;

  always #5 clk = ~clk;

  flow_trace_top dut_i (
    .clk(clk), .rstN(rstN), .retireValid(retireValid), .isJump(isJump),
    .srcPc(srcPc), .dstPc(dstPc), .recEnable(recEnable), .clearReq(clearReq),
    .rdIdx(rdIdx), .rdSrcPc(rdSrcPc), .rdDstPc(rdDstPc),
    .fillCount(fillCount), .overflow(overflow), .fullIrq(fullIrq)
  );

  typedef struct { logic [31:0] s; logic [31:0] d; } ent_t;
  ent_t  refQ[$];
  bit    refOvf;
  int    nChecks = 0;
  int    nBad    = 0;
  bit    finished = 0;
  string phase = "R1";

  task automatic checkVal(string tag, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s act=%h exp=%h (phase %s)", tag, what, act, exp, phase);
    end
  endtask

  // Compare every observable against the model
  task automatic compareAll();
    checkVal("R2", "fillCount", 32'(fillCount), 32'(refQ.size()));
    checkVal("R9", "overflow", 32'(overflow), 32'(refOvf));
    checkVal("R7", "fullIrq", 32'(fullIrq), 32'(refQ.size() == DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      rdIdx = 4'(i);
      #0.2;
      if (i < refQ.size()) begin
        checkVal("R5", "rdSrcPc", rdSrcPc, refQ[i].s);
        checkVal("R5", "rdDstPc", rdDstPc, refQ[i].d);
      end else begin
        checkVal("R6", "rdSrcPc", rdSrcPc, 32'h0);
        checkVal("R6", "rdDstPc", rdDstPc, 32'h0);
      end
    end
  endtask

  task automatic step(bit v, bit j, bit e, bit c, logic [31:0] s, logic [31:0] d);
    ent_t x;
    @(negedge clk);
    retireValid = v; isJump = j; recEnable = e; clearReq = c;
    srcPc = s; dstPc = d;
    @(posedge clk);
    if (c) begin
      refQ.delete();
      refOvf = 1'b0;
    end else if (v && j && e) begin
      if (refQ.size() == DEPTH) begin
        void'(refQ.pop_back());
        refOvf = 1'b1;
      end
      x.s = s; x.d = d;
      refQ.push_front(x);
    end
    #1;
    compareAll();
  endtask

  initial begin
    rstN = 1'b0; retireValid = 0; isJump = 0; recEnable = 0; clearReq = 0;
    srcPc = '0; dstPc = '0; rdIdx = '0; refOvf = 0;
    repeat (3) @(posedge clk);
    #1;
    phase = "R1";
    compareAll();
    @(negedge clk) rstN = 1'b1;

    phase = "R3";
    for (int k = 0; k < 6; k++) step(1, 0, 1, 0, 32'h100 + 32'(4*k), 32'h104 + 32'(4*k));
    step(0, 1, 1, 0, 32'hdead0000, 32'hbeef0000);

    phase = "R2";
    for (int k = 0; k < 5; k++) step(1, 1, 1, 0, 32'h1000 + 32'(k), 32'h8000 + 32'(k));

    phase = "R4";
    for (int k = 0; k < 4; k++) step(1, 1, 0, 0, 32'hfff0 + 32'(k), 32'heee0 + 32'(k));

    phase = "R7";
    for (int k = 5; k < 16; k++) step(1, 1, 1, 0, 32'h1000 + 32'(k), 32'h8000 + 32'(k));
    step(1, 0, 1, 0, 32'h0, 32'h0);

    phase = "R8";
    for (int k = 16; k < 23; k++) step(1, 1, 1, 0, 32'h1000 + 32'(k), 32'h8000 + 32'(k));
    phase = "R9";
    step(0, 0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 32'h5, 32'h6);

    phase = "R10";
    step(1, 1, 1, 1, 32'haaaa, 32'hbbbb);
    for (int k = 0; k < 3; k++) step(1, 1, 1, 0, 32'h2000 + 32'(k), 32'h3000 + 32'(k));
    step(0, 0, 1, 1, 0, 0);

    phase = "mix";
    for (int k = 0; k < 400; k++)
      step(($urandom % 4) != 0, $urandom % 2 == 1, ($urandom % 8) != 0,
           ($urandom % 50) == 0, $urandom, $urandom);

    finished = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++;
      nBad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end
endmodule